// File: doc/BRIEF.md
# Load-Use Interlock and Branch Squash Controller

This block decides, every cycle, whether the front of a five-stage in-order pipeline may advance. It looks at the instruction in the execute stage and the instruction in decode. When the execute-stage instruction is a load, and its destination is a register that the decode-stage instruction is about to read, the value cannot arrive in time through ALU forwarding. In that case the block holds the program counter and the fetch/decode register for one cycle. It also tells the decode/execute register to take an empty instruction, one with every write control cleared, in place of the held one. After that single cycle the load result can be forwarded, so the penalty is one cycle. When there is no dependent reader, there is no penalty.

The block also handles control flow. Branches are assumed not taken. When the branch in execute turns out to be taken, the block squashes the wrong-path instruction that follows it. If a stall and a squash are requested in the same cycle, the squash wins.

A store whose data operand depends on the preceding load is stalled by default. A parameter can instead leave that case to a memory-stage forwarding path. The unit is purely combinational: its outputs follow its inputs within the same cycle and it holds no state. The pipeline registers it steers are expected to reset to an empty instruction.

Top module: `hz_stall_unit`

## Requirements
- R1: When `ex_load`=1, `ex_dst`≠0, `dec_reads_a`=1, `ex_dst`=`dec_src_a` and `br_taken`=0, the outputs are stall: `pc_we`=0, `fd_we`=0, `de_bubble`=1, `fd_flush`=0.
- R2: When `ex_load`=1, `ex_dst`≠0, `dec_reads_b`=1, `ex_dst`=`dec_src_b`, the decode instruction is not a store and `br_taken`=0, the outputs are stall (as in R1).
- R3: When `ex_dst` is register 0, no stall is raised, even if both sources equal 0 and are read.
- R4: When `ex_load`=0, no stall is raised, whatever the register fields hold.
- R5: A source whose read flag (`dec_reads_a` or `dec_reads_b`) is 0 never causes a stall, even when its index equals `ex_dst`.
- R6: A store (`dec_is_store`=1) whose data operand `dec_src_b` equals the load destination is stalled when `STORE_DATA_FWD`=0. When `STORE_DATA_FWD`=1 it proceeds without a stall, unless `dec_src_a` also matches.
- R7: With no hazard and no taken branch, everything advances: `pc_we`=1, `fd_we`=1, `de_bubble`=0, `fd_flush`=0.
- R8: When `br_taken`=1, the outputs are squash: `fd_flush`=1, `de_bubble`=1, `pc_we`=1, `fd_we`=1.
- R9: When `br_taken`=1 and a stall condition is present at the same time, the outputs are exactly the squash outputs of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_load | input | 1 | Instruction in execute reads data memory (is a load) |
| ex_dst | input | REG_AW | Destination register of the execute-stage load |
| dec_src_a | input | REG_AW | First source register index of the decode instruction |
| dec_src_b | input | REG_AW | Second source register index (store data for a store) |
| dec_reads_a | input | 1 | Decode instruction really reads `dec_src_a` |
| dec_reads_b | input | 1 | Decode instruction really reads `dec_src_b` |
| dec_is_store | input | 1 | Decode instruction is a store |
| br_taken | input | 1 | Branch in execute resolved taken |
| pc_we | output | 1 | Program counter update enable |
| fd_we | output | 1 | Fetch/decode register update enable |
| de_bubble | output | 1 | Decode/execute register takes an empty instruction |
| fd_flush | output | 1 | Fetch/decode register is cleared to an empty instruction |

## Verification
The assertions check on every evaluation that a squash always wins over a stall and never freezes the front end. They also check that a write enable is dropped only together with a bubble, that register 0 and non-load instructions never freeze anything, and that a load match on the first operand always freezes. Only the bench's scenarios show how the read flags mask a false match and how the store-data case changes with the forwarding parameter. They also show that the maximum register index matches correctly, and that the idle state lets everything advance.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef struct packed {
    logic pc_we;
    logic fd_we;
    logic de_bubble;
    logic fd_flush;
  } hz_ctrl_t;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int REG_AW       = 5,
  parameter bit HAS_ZERO_REG = 1'b1
) (
  input  logic              producer_load,
  input  logic [REG_AW-1:0] producer_dst,
  input  logic [REG_AW-1:0] consumer_src,
  input  logic              consumer_reads,
  output logic              hit
);
  logic dst_live;

  generate
    if (HAS_ZERO_REG) begin : g_zero
      // index 0 is hard-wired and never carries a loaded value
      assign dst_live = |producer_dst;
    end else begin : g_nozero
      assign dst_live = 1'b1;
    end
  endgenerate

  assign hit = producer_load & dst_live & consumer_reads &
               (producer_dst == consumer_src);
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det #(
  parameter int REG_AW         = 5,
  parameter bit HAS_ZERO_REG   = 1'b1,
  parameter bit STORE_DATA_FWD = 1'b0
) (
  input  logic              ex_load,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic              dec_reads_a,
  input  logic              dec_reads_b,
  input  logic              dec_is_store,
  output logic              stall_req
);
  localparam int NSRC = 2;

  logic [REG_AW-1:0] src   [NSRC];
  logic              reads [NSRC];
  logic [NSRC-1:0]   hits;
  logic              b_covered;

  assign src[0]   = dec_src_a;
  assign src[1]   = dec_src_b;
  assign reads[0] = dec_reads_a;
  assign reads[1] = dec_reads_b;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      hz_src_match #(
        .REG_AW      (REG_AW),
        .HAS_ZERO_REG(HAS_ZERO_REG)
      ) u_match (
        .producer_load (ex_load),
        .producer_dst  (ex_dst),
        .consumer_src  (src[i]),
        .consumer_reads(reads[i]),
        .hit           (hits[i])
      );
    end
  endgenerate

  // store data may be served later by a memory-stage bypass
  assign b_covered = dec_is_store & STORE_DATA_FWD;
  assign stall_req = hits[0] | (hits[1] & ~b_covered);
endmodule

// File: rtl/hz_branch_squash.sv
module hz_branch_squash (
  input  logic br_taken,
  output logic squash_req
);
  // not-taken prediction: only a taken outcome needs repair
  assign squash_req = br_taken;
endmodule

// File: rtl/hz_ctrl_merge.sv
module hz_ctrl_merge
  import hz_pkg::*;
(
  input  logic     stall_req,
  input  logic     squash_req,
  output hz_ctrl_t ctrl
);
  always_comb begin
    ctrl = '{pc_we: 1'b1, fd_we: 1'b1, de_bubble: 1'b0, fd_flush: 1'b0};
    if (squash_req) begin
      // redirect wins: front end loads the target path
      ctrl.fd_flush  = 1'b1;
      ctrl.de_bubble = 1'b1;
    end else if (stall_req) begin
      ctrl.pc_we     = 1'b0;
      ctrl.fd_we     = 1'b0;
      ctrl.de_bubble = 1'b1;
    end
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_AW         = 5,
  parameter bit HAS_ZERO_REG   = 1'b1,
  parameter bit STORE_DATA_FWD = 1'b0
) (
  input  logic              ex_load,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic              dec_reads_a,
  input  logic              dec_reads_b,
  input  logic              dec_is_store,
  input  logic              br_taken,
  output logic              pc_we,
  output logic              fd_we,
  output logic              de_bubble,
  output logic              fd_flush
);
  logic     stall_req;
  logic     squash_req;
  hz_ctrl_t ctrl;

  hz_loaduse_det #(
    .REG_AW        (REG_AW),
    .HAS_ZERO_REG  (HAS_ZERO_REG),
    .STORE_DATA_FWD(STORE_DATA_FWD)
  ) u_det (
    .ex_load     (ex_load),
    .ex_dst      (ex_dst),
    .dec_src_a   (dec_src_a),
    .dec_src_b   (dec_src_b),
    .dec_reads_a (dec_reads_a),
    .dec_reads_b (dec_reads_b),
    .dec_is_store(dec_is_store),
    .stall_req   (stall_req)
  );

  hz_branch_squash u_sq (
    .br_taken  (br_taken),
    .squash_req(squash_req)
  );

  hz_ctrl_merge u_merge (
    .stall_req (stall_req),
    .squash_req(squash_req),
    .ctrl      (ctrl)
  );

  assign pc_we     = ctrl.pc_we;
  assign fd_we     = ctrl.fd_we;
  assign de_bubble = ctrl.de_bubble;
  assign fd_flush  = ctrl.fd_flush;

  always_comb begin
    // R8
    squash_advances_chk: assert (!br_taken || (fd_flush && de_bubble && pc_we && fd_we));
    // R7
    freeze_needs_bubble_chk: assert (pc_we || (de_bubble && !fd_flush && !fd_we));
    // R3
    zero_dst_quiet_chk: assert (!(HAS_ZERO_REG && ex_dst == '0) || (de_bubble == br_taken && pc_we));
    // R4
    non_load_quiet_chk: assert (ex_load || (de_bubble == br_taken && pc_we && fd_we));
    // R1
    src_a_freeze_chk: assert (!(ex_load && ex_dst != '0 && dec_reads_a &&
                                ex_dst == dec_src_a && !br_taken) || (!pc_we && de_bubble));
    // R6
    store_data_chk: assert (!(STORE_DATA_FWD == 1'b0 && ex_load && ex_dst != '0 &&
                              dec_is_store && dec_reads_b && ex_dst == dec_src_b &&
                              !br_taken) || !fd_we);
  end
endmodule

// File: tb/hz_stall_unit_tb.sv
`timescale 1ns/1ps
module hz_stall_unit_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       ex_load, dec_reads_a, dec_reads_b, dec_is_store, br_taken;
  logic [4:0] ex_dst, dec_src_a, dec_src_b;
  logic       pc_we, fd_we, de_bubble, fd_flush;
  logic       f_pc_we, f_fd_we, f_de_bubble, f_fd_flush;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  hz_stall_unit u_dut (
    .ex_load(ex_load), .ex_dst(ex_dst), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_reads_a(dec_reads_a), .dec_reads_b(dec_reads_b), .dec_is_store(dec_is_store),
    .br_taken(br_taken), .pc_we(pc_we), .fd_we(fd_we), .de_bubble(de_bubble),
    .fd_flush(fd_flush)
  );

  hz_stall_unit #(.STORE_DATA_FWD(1'b1)) u_dut_fwd (
    .ex_load(ex_load), .ex_dst(ex_dst), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_reads_a(dec_reads_a), .dec_reads_b(dec_reads_b), .dec_is_store(dec_is_store),
    .br_taken(br_taken), .pc_we(f_pc_we), .fd_we(f_fd_we), .de_bubble(f_de_bubble),
    .fd_flush(f_fd_flush)
  );

  // {req, load, dst, src_a, src_b, reads_a, reads_b, store, br, exp{pc,fd,bub,flush}}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {4'd7, 1'b1, 5'd3,  5'd4,  5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1100}, // R7 no match
    {4'd1, 1'b1, 5'd3,  5'd3,  5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0010}, // R1
    {4'd1, 1'b1, 5'd31, 5'd31, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0010}, // R1 top index
    {4'd2, 1'b1, 5'd6,  5'd1,  5'd6, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0010}, // R2
    {4'd3, 1'b1, 5'd0,  5'd0,  5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1100}, // R3
    {4'd4, 1'b0, 5'd3,  5'd3,  5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1100}, // R4
    {4'd5, 1'b1, 5'd9,  5'd9,  5'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1100}, // R5 a unread
    {4'd5, 1'b1, 5'd9,  5'd2,  5'd9, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1100}, // R5 b unread
    {4'd6, 1'b1, 5'd7,  5'd1,  5'd7, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0010}, // R6 default stalls
    {4'd8, 1'b0, 5'd0,  5'd0,  5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1111}, // R8
    {4'd9, 1'b1, 5'd3,  5'd3,  5'd3, 1'b1, 1'b1, 1'b0, 1'b1, 4'b1111}  // R9
  };

  task automatic apply(input logic [23:0] s);
    @(negedge clk);
    {ex_load, ex_dst, dec_src_a, dec_src_b, dec_reads_a, dec_reads_b, dec_is_store, br_taken} = s[23:4];
    #1;
  endtask

  task automatic check(input int req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // idle state after reset of the surrounding pipeline: all inputs low (R7)
    apply(24'h0);
    check(7, {pc_we, fd_we, de_bubble, fd_flush}, 4'b1100);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][23:0]);
      check(int'(VEC[i][27:24]), {pc_we, fd_we, de_bubble, fd_flush}, VEC[i][3:0]);
    end

    // R6 with memory-stage store forwarding: data match alone passes
    apply({1'b1, 5'd7, 5'd1, 5'd7, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0});
    check(6, {f_pc_we, f_fd_we, f_de_bubble, f_fd_flush}, 4'b1100);
    // R6 address operand still stalls
    apply({1'b1, 5'd7, 5'd7, 5'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0});
    check(6, {f_pc_we, f_fd_we, f_de_bubble, f_fd_flush}, 4'b0010);
    // R2 non-store b match still stalls in the forwarding variant
    apply({1'b1, 5'd7, 5'd1, 5'd7, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0});
    check(2, {f_pc_we, f_fd_we, f_de_bubble, f_fd_flush}, 4'b0010);
    // R9 squash beats stall in the variant too
    apply({1'b1, 5'd7, 5'd7, 5'd7, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0});
    check(9, {f_pc_we, f_fd_we, f_de_bubble, f_fd_flush}, 4'b1111);

    finish_run();
  end
endmodule